// File: doc/BRIEF.md
# Synchronizable Clock Output Divider Channel

This block is one output channel of a clock distribution tree. It divides a fast input clock by an integer ratio and can shift the result in half-input-cycle steps. Three broadcast strobes move it at run time. A sync request arms the channel, and the next tick of a central reference timer realigns its counter. A slip request freezes the counter for a few input cycles, which delays the output phase. A pulse request lets a muted channel emit a short burst of periods.

Each channel decides which of these strobes it obeys. It has its own slip and sync enables, a 2-bit start mode and a phase offset. The offset sets how long the counter waits after a realignment. It also sets how many cycles one slip lasts.

The divided output is built so that odd ratios still give an exact 50% duty cycle. Ratio one hands the gated input clock straight through. All positions below are counted in half input cycles. Half-cycle sample slots alternate: first the slot after a rising edge, then the slot after the following falling edge.

Top module: `syncdiv_chan`

## Requirements
- R1: The effective ratio N is `cfg_ratio` bounded to 1..4094: the value 0 acts as 1 and 4095 acts as 4094. For even N the output repeats every N input cycles and stays high for N/2 of them.
- R2: For odd N of 3 or more the output period is N input cycles and the output is high for exactly N half cycles of it.
- R3: When N is 1 the output equals the input clock (inverted when `cfg_coarse[0]` is 1), and it is forced low while the channel is muted or its counter is frozen.
- R4: A coarse setting d (0..31) delays the output by d half cycles. Bits 4:1 give whole cycles and bit 0 gives one half cycle. The half-cycle choice also picks whether the output is launched on the falling edge (bit 0 = 0) or on the rising edge (bit 0 = 1). The output lags the internal counter phase by d+1 half cycles.
- R5: A slip request taken while `cfg_slip_en` is 1 freezes the counter for K input cycles, where K is `cfg_offset`, or 1 when the offset is 0. The output phase therefore moves K cycles later.
- R6: A sync request taken while `cfg_sync_en` is 1 arms the channel. The next `ref_tick` loads the counter to its last state and then holds it for `cfg_offset` cycles. The output's next rising edge then comes 2·(offset+1)+d+1 half cycles after the edge that sampled the tick, one half cycle later for odd N. A `ref_tick` with nothing armed has no effect.
- R7: While a sync is armed, a sync hold is running, or a slip is running, new sync and slip requests are dropped. When a sync and a slip are requested in the same cycle, the sync is taken and the slip is dropped.
- R8: A slip request with `cfg_slip_en` at 0 has no effect, and so does a sync request with `cfg_sync_en` at 0.
- R9: `cfg_start_mode` selects how the output starts. 0: free running. 1: low, with the counter held, until the first completed sync. 2: muted until a pulse request; the next counter wrap then starts exactly 4 full periods, and pulse requests are dropped while a burst is pending or running. 3: always low.
- R10: With N of 2 or more, the output is low while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | High-rate input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ratio | input | 12 | Requested divide ratio |
| cfg_coarse | input | 5 | Coarse delay in half input cycles |
| cfg_offset | input | 8 | Post-sync hold length and slip length |
| cfg_slip_en | input | 1 | Channel obeys slip requests |
| cfg_sync_en | input | 1 | Channel obeys sync requests |
| cfg_start_mode | input | 2 | 0 free, 1 wait for sync, 2 pulse burst, 3 off |
| sync_req | input | 1 | Broadcast sync strobe, one cycle |
| slip_req | input | 1 | Broadcast slip strobe, one cycle |
| pulse_req | input | 1 | Broadcast pulse-burst strobe, one cycle |
| ref_tick | input | 1 | Phase tick from the central reference timer |
| div_out | output | 1 | Divided clock |

## Verification
A sync and a slip can both be requested in the same input cycle, and only one of them may move the counter. The bench provokes this by raising both strobes together, and also by sending a slip while a sync is still armed or while a post-sync hold is running. Its reference model takes the sync and drops the slip. The bench then judges the result from where the output edges land after the next reference tick, compared half cycle by half cycle against that model.

// File: rtl/syncdiv_pkg.sv
package syncdiv_pkg;

  typedef enum logic [1:0] {
    SM_FREE      = 2'd0,
    SM_WAIT_SYNC = 2'd1,
    SM_PULSE     = 2'd2,
    SM_OFF       = 2'd3
  } start_mode_t;

  // bound a requested ratio into 1..maxr
  function automatic int eff_ratio(input int req, input int maxr);
    if (req < 1) return 1;
    if (req > maxr) return maxr;
    return req;
  endfunction

  // cycles the raw phase stays high within one period (rounded up)
  function automatic int high_len(input int n);
    return (n + 1) / 2;
  endfunction

  // cycles one slip request freezes the counter
  function automatic int slip_len(input int ofs);
    return (ofs == 0) ? 1 : ofs;
  endfunction

endpackage

// File: rtl/syncdiv_evt.sv
module syncdiv_evt #(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_en,
  input  logic             slip_en,
  input  logic [OFS_W-1:0] offset,
  input  logic             sync_req,
  input  logic             slip_req,
  input  logic             ref_tick,
  output logic             armed,
  output logic             synced,
  output logic [OFS_W-1:0] wait_left,
  output logic [OFS_W-1:0] slip_left,
  output logic             busy,
  output logic             reload,
  output logic             hold
);
  import syncdiv_pkg::*;

  logic take_sync, take_slip;

  always_comb begin
    busy      = armed | (wait_left != '0) | (slip_left != '0);
    take_sync = sync_req & sync_en & ~busy;
    take_slip = slip_req & slip_en & ~busy & ~take_sync;
    reload    = armed & ref_tick;
    hold      = (wait_left != '0) | (slip_left != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      synced    <= 1'b0;
      wait_left <= '0;
      slip_left <= '0;
    end else begin
      if (reload) begin
        armed     <= 1'b0;
        synced    <= 1'b1;
        wait_left <= offset;
      end else if (wait_left != '0) begin
        wait_left <= wait_left - 1'b1;
      end else if (slip_left != '0) begin
        slip_left <= slip_left - 1'b1;
      end
      if (take_sync) armed <= 1'b1;
      if (take_slip) slip_left <= OFS_W'(slip_len(int'(offset)));
    end
  end

endmodule

// File: rtl/syncdiv_cnt.sv
module syncdiv_cnt #(
  parameter int RATIO_W = 12,
  parameter int NPULSE  = 4,
  parameter int PW      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] n_eff,
  input  logic [RATIO_W-1:0] hi_len,
  input  logic [1:0]         mode,
  input  logic               reload,
  input  logic               hold,
  input  logic               synced,
  input  logic               pulse_req,
  output logic [RATIO_W-1:0] cnt_q,
  output logic [PW-1:0]      pulse_left,
  output logic               r_raw,
  output logic               run
);
  import syncdiv_pkg::*;

  logic held1, advance, wrap, pend, en;
  logic [RATIO_W-1:0] last;

  always_comb begin
    last    = n_eff - 1'b1;
    held1   = (mode == SM_WAIT_SYNC) & ~synced;
    advance = ~reload & ~hold & ~held1;
    wrap    = advance & (cnt_q >= last);
    case (mode)
      SM_FREE:      en = 1'b1;
      SM_WAIT_SYNC: en = synced;
      SM_PULSE:     en = (pulse_left != '0);
      default:      en = 1'b0;
    endcase
    r_raw = en & (cnt_q < hi_len);
    run   = en & ~hold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (reload) begin
      cnt_q <= last;
    end else if (hold) begin
      cnt_q <= cnt_q;
    end else if (held1) begin
      cnt_q <= last;
    end else if (wrap) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      pulse_left <= '0;
    end else if (mode != SM_PULSE) begin
      pend       <= 1'b0;
      pulse_left <= '0;
    end else if (wrap && pend) begin
      pend       <= 1'b0;
      pulse_left <= PW'(NPULSE);
    end else begin
      if (wrap && (pulse_left != '0)) pulse_left <= pulse_left - 1'b1;
      if (pulse_req && !pend && (pulse_left == '0)) pend <= 1'b1;
    end
  end

endmodule

// File: rtl/syncdiv_phase.sv
module syncdiv_phase #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] dly_whole,
  input  logic          dly_half,
  input  logic          r_raw,
  input  logic          run,
  input  logic          single,
  input  logic          odd,
  output logic          out
);
  localparam int DMAX = (1 << DW) - 1;

  logic [DMAX:1] line;
  logic [DMAX:0] taps;
  logic rd, a_n, a_p, f_n, f_p, a_sel, f_sel;

  assign taps = {line, r_raw};
  assign rd   = taps[dly_whole];

  generate
    if (DMAX == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) line <= '0;
        else        line <= r_raw;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) line <= '0;
        else        line <= {line[DMAX-1:1], r_raw};
    end
  endgenerate

  // falling-edge launch and its rising-edge follower
  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) a_n <= 1'b0;
    else        a_n <= rd;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) f_p <= 1'b0;
    else        f_p <= a_n;

  // rising-edge launch and its falling-edge follower
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) a_p <= 1'b0;
    else        a_p <= rd;
  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) f_n <= 1'b0;
    else        f_n <= a_p;

  always_comb begin
    a_sel = dly_half ? a_p : a_n;
    f_sel = dly_half ? f_n : f_p;
    if (single)   out = run & (dly_half ? ~clk : clk);
    else if (odd) out = a_sel & f_sel;
    else          out = a_sel;
  end

endmodule

// File: rtl/syncdiv_chan.sv
module syncdiv_chan #(
  parameter int RATIO_W = 12,
  parameter int OFS_W   = 8,
  parameter int CD_W    = 5,
  parameter int NPULSE  = 4
) (
  input  logic               clk_in,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] cfg_ratio,
  input  logic [CD_W-1:0]    cfg_coarse,
  input  logic [OFS_W-1:0]   cfg_offset,
  input  logic               cfg_slip_en,
  input  logic               cfg_sync_en,
  input  logic [1:0]         cfg_start_mode,
  input  logic               sync_req,
  input  logic               slip_req,
  input  logic               pulse_req,
  input  logic               ref_tick,
  output logic               div_out
);
  import syncdiv_pkg::*;

  localparam int MAX_R = (1 << RATIO_W) - 2;
  localparam int PW    = $clog2(NPULSE + 1);
  localparam int DW    = CD_W - 1;

  logic [RATIO_W-1:0] n_eff, hi_len, cnt_q;
  logic [OFS_W-1:0]   wait_left, slip_left;
  logic [PW-1:0]      pulse_left;
  logic armed, synced, busy, reload, hold, r_raw, run, single, odd;

  always_comb begin
    n_eff  = RATIO_W'(eff_ratio(int'(cfg_ratio), MAX_R));
    hi_len = RATIO_W'(high_len(int'(n_eff)));
    single = (n_eff == RATIO_W'(1));
    odd    = n_eff[0] & ~single;
  end

  syncdiv_evt #(.OFS_W(OFS_W)) u_evt (
    .clk(clk_in), .rst_n(rst_n), .sync_en(cfg_sync_en), .slip_en(cfg_slip_en),
    .offset(cfg_offset), .sync_req(sync_req), .slip_req(slip_req),
    .ref_tick(ref_tick), .armed(armed), .synced(synced),
    .wait_left(wait_left), .slip_left(slip_left), .busy(busy),
    .reload(reload), .hold(hold)
  );

  syncdiv_cnt #(.RATIO_W(RATIO_W), .NPULSE(NPULSE), .PW(PW)) u_cnt (
    .clk(clk_in), .rst_n(rst_n), .n_eff(n_eff), .hi_len(hi_len),
    .mode(cfg_start_mode), .reload(reload), .hold(hold), .synced(synced),
    .pulse_req(pulse_req), .cnt_q(cnt_q), .pulse_left(pulse_left),
    .r_raw(r_raw), .run(run)
  );

  syncdiv_phase #(.DW(DW)) u_phase (
    .clk(clk_in), .rst_n(rst_n), .dly_whole(cfg_coarse[CD_W-1:1]),
    .dly_half(cfg_coarse[0]), .r_raw(r_raw), .run(run), .single(single),
    .odd(odd), .out(div_out)
  );

endmodule

// File: rtl/syncdiv_chk.sv
module syncdiv_chk #(
  parameter int RATIO_W = 12,
  parameter int OFS_W   = 8,
  parameter int NPULSE  = 4,
  parameter int PW      = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [OFS_W-1:0]   cfg_offset,
  input logic [1:0]         cfg_start_mode,
  input logic [RATIO_W-1:0] cnt_q,
  input logic [OFS_W-1:0]   wait_left,
  input logic [OFS_W-1:0]   slip_left,
  input logic [PW-1:0]      pulse_left,
  input logic               armed,
  input logic               reload,
  input logic               hold,
  input logic               r_raw
);
  localparam int MAX_R = (1 << RATIO_W) - 2;

  // R7
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((slip_left != '0) && (armed || (wait_left != '0))));

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < MAX_R);

  // R5
  slip_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_left != '0) |=> (slip_left == $past(slip_left) - 1'b1));

  // R5
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt_q == $past(cnt_q)));

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> ((wait_left == $past(cfg_offset)) && !armed));

  // R9
  pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pulse_left) <= NPULSE);

  // R9
  off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_start_mode == 2'd3) |-> !r_raw);

endmodule

bind syncdiv_chan syncdiv_chk #(
  .RATIO_W(RATIO_W), .OFS_W(OFS_W), .NPULSE(NPULSE), .PW(PW)
) u_chk (
  .clk(clk_in), .rst_n(rst_n), .cfg_offset(cfg_offset),
  .cfg_start_mode(cfg_start_mode), .cnt_q(cnt_q), .wait_left(wait_left),
  .slip_left(slip_left), .pulse_left(pulse_left), .armed(armed),
  .reload(reload), .hold(hold), .r_raw(r_raw)
);

// File: tb/sim_syncdiv_chan.sv
`timescale 1ns/1ps
module sim_syncdiv_chan;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] cfg_ratio = 12'd4;
  logic [4:0]  cfg_coarse = '0;
  logic [7:0]  cfg_offset = '0;
  logic cfg_slip_en = 0, cfg_sync_en = 0;
  logic [1:0] cfg_start_mode = '0;
  logic sync_req = 0, slip_req = 0, pulse_req = 0, ref_tick = 0;
  logic div_out;

  int total = 0, bad = 0;
  bit done = 0;
  string tag = "R10";

  syncdiv_chan u0 (
    .clk_in(clk), .rst_n(rst_n), .cfg_ratio(cfg_ratio), .cfg_coarse(cfg_coarse),
    .cfg_offset(cfg_offset), .cfg_slip_en(cfg_slip_en), .cfg_sync_en(cfg_sync_en),
    .cfg_start_mode(cfg_start_mode), .sync_req(sync_req), .slip_req(slip_req),
    .pulse_req(pulse_req), .ref_tick(ref_tick), .div_out(div_out)
  );

  always #4 clk = ~clk;

  // ---------------- reference model ----------------
  int m_cnt, m_wait, m_slip, m_left, k_now, since_rel;
  bit m_armed, m_synced, m_pend;
  bit rq[$];
  bit runq[$];

  function automatic int n_of(input int req);
    if (req == 0) return 1;
    if (req > 4094) return 4094;
    return req;
  endfunction

  task automatic model_step();
    int n, hi, ofs, slen;
    bit busy, tsync, tslip, rel, held1, hold, adv, wrp, en;
    n = n_of(int'(cfg_ratio));
    hi = (n + 1) / 2;
    ofs = int'(cfg_offset);
    slen = (ofs == 0) ? 1 : ofs;
    if (!rst_n) begin
      m_cnt = 0; m_wait = 0; m_slip = 0; m_left = 0;
      m_armed = 0; m_synced = 0; m_pend = 0; since_rel = 0;
    end else begin
      since_rel++;
      busy  = m_armed || m_wait != 0 || m_slip != 0;
      tsync = sync_req && cfg_sync_en && !busy;
      tslip = slip_req && cfg_slip_en && !busy && !tsync;
      rel   = m_armed && ref_tick;
      held1 = cfg_start_mode == 1 && !m_synced;
      hold  = m_wait != 0 || m_slip != 0;
      adv   = !rel && !hold && !held1;
      wrp   = adv && m_cnt >= n - 1;
      if (cfg_start_mode != 2) begin
        m_pend = 0; m_left = 0;
      end else if (wrp && m_pend) begin
        m_pend = 0; m_left = 4;
      end else begin
        bit was_idle;
        was_idle = (m_left == 0);
        if (wrp && m_left != 0) m_left--;
        if (pulse_req && !m_pend && was_idle) m_pend = 1;
      end
      if (rel) m_cnt = n - 1;
      else if (hold) m_cnt = m_cnt;
      else if (held1) m_cnt = n - 1;
      else if (wrp) m_cnt = 0;
      else m_cnt++;
      if (rel) begin
        m_armed = 0; m_synced = 1; m_wait = ofs;
      end else if (m_wait != 0) m_wait--;
      else if (m_slip != 0) m_slip--;
      if (tsync) m_armed = 1;
      if (tslip) m_slip = slen;
    end
    case (cfg_start_mode)
      2'd0: en = 1;
      2'd1: en = m_synced;
      2'd2: en = (m_left != 0);
      default: en = 0;
    endcase
    rq.push_back(en && m_cnt < hi);
    runq.push_back(en && !(m_wait != 0 || m_slip != 0));
  endtask

  function automatic bit a_at(input int p);
    int q, idx;
    q = p - 1 - int'(cfg_coarse[0]);
    if (q < 0) return 0;
    idx = q / 2 - int'(cfg_coarse[4:1]);
    if (idx < 0) return 0;
    return rq[idx];
  endfunction

  function automatic bit expect_at(input int p);
    int n;
    n = n_of(int'(cfg_ratio));
    if (n == 1) return runq[p / 2] && (cfg_coarse[0] ? (p % 2 == 1) : (p % 2 == 0));
    if (n % 2 == 1) return a_at(p) && a_at(p - 1);
    return a_at(p);
  endfunction

  task automatic compare(input int p);
    bit e;
    if (!rst_n || since_rel < 40) return;
    e = expect_at(p);
    total++;
    if (div_out !== e) begin
      bad++;
      $display("FAIL %s half-slot %0d: div_out=%b expected=%b", tag, p, div_out, e);
    end
  endtask

  initial begin
    k_now = -1;
    forever begin
      @(posedge clk);
      k_now++;
      model_step();
      #2 compare(2 * k_now);
      #4 compare(2 * k_now + 1);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic setup(input string t, input int ratio, input int crs, input int ofs,
                       input bit slip_en, input bit sync_en, input int mode);
    @(posedge clk); #5;
    rst_n = 0;
    cfg_ratio = 12'(ratio); cfg_coarse = 5'(crs); cfg_offset = 8'(ofs);
    cfg_slip_en = slip_en; cfg_sync_en = sync_en; cfg_start_mode = 2'(mode);
    tag = "R10";
    repeat (3) begin
      @(posedge clk); #2;
      if (n_of(ratio) >= 2) begin
        total++;
        if (div_out !== 1'b0) begin
          bad++; $display("FAIL R10 in reset: div_out=%b expected=0", div_out);
        end
      end
      #4;
      if (n_of(ratio) >= 2) begin
        total++;
        if (div_out !== 1'b0) begin
          bad++; $display("FAIL R10 in reset: div_out=%b expected=0", div_out);
        end
      end
    end
    @(posedge clk); #5;
    rst_n = 1;
    tag = t;
  endtask

  task automatic strobe(input bit s_sync, input bit s_slip, input bit s_pulse, input bit s_ref);
    @(posedge clk); #5;
    sync_req = s_sync; slip_req = s_slip; pulse_req = s_pulse; ref_tick = s_ref;
    @(posedge clk); #5;
    sync_req = 0; slip_req = 0; pulse_req = 0; ref_tick = 0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: even ratios and clamping
    setup("R1", 4, 0, 0, 0, 0, 0);    idle(80);
    setup("R1", 2, 0, 0, 0, 0, 0);    idle(60);
    setup("R1", 10, 0, 0, 0, 0, 0);   idle(90);
    setup("R1", 0, 0, 0, 0, 0, 0);    idle(60);
    setup("R1", 4095, 0, 0, 0, 0, 0); idle(9000);
    // R2: odd ratios
    setup("R2", 3, 0, 0, 0, 0, 0);    idle(60);
    setup("R2", 5, 0, 0, 0, 0, 0);    idle(60);
    setup("R2", 7, 1, 0, 0, 0, 0);    idle(70);
    // R3: pass-through
    setup("R3", 1, 0, 0, 0, 0, 0);    idle(60);
    setup("R3", 1, 1, 0, 0, 0, 0);    idle(60);
    // R4: coarse delay
    setup("R4", 6, 7, 0, 0, 0, 0);    idle(70);
    setup("R4", 6, 31, 0, 0, 0, 0);   idle(80);
    setup("R4", 5, 13, 0, 0, 0, 0);   idle(70);
    // R5: slips
    setup("R5", 8, 0, 3, 1, 0, 0);    idle(45); strobe(0, 1, 0, 0); idle(40);
    setup("R5", 8, 2, 0, 1, 0, 0);    idle(45); strobe(0, 1, 0, 0); idle(40);
    setup("R5", 1, 0, 2, 1, 0, 0);    idle(45); strobe(0, 1, 0, 0); idle(20);
    // R6: sync alignment
    setup("R6", 6, 3, 2, 0, 1, 0);    idle(45); strobe(0, 0, 0, 1); idle(5);
    strobe(1, 0, 0, 0); idle(4); strobe(0, 0, 0, 1); idle(40);
    setup("R6", 7, 0, 0, 0, 1, 0);    idle(45); strobe(1, 0, 0, 0); idle(3);
    strobe(0, 0, 0, 1); idle(40);
    // R7: collisions and busy drops
    setup("R7", 8, 0, 6, 1, 1, 0);    idle(45); strobe(0, 1, 0, 0); idle(1);
    strobe(0, 1, 0, 0); strobe(1, 0, 0, 0); idle(30);
    strobe(1, 1, 0, 0); idle(2); strobe(0, 1, 0, 0); idle(2);
    strobe(0, 0, 0, 1); strobe(0, 1, 0, 0); idle(40);
    // R8: disabled channels
    setup("R8", 6, 0, 3, 0, 0, 0);    idle(45); strobe(0, 1, 0, 0); idle(10);
    strobe(1, 0, 0, 0); idle(2); strobe(0, 0, 0, 1); idle(40);
    // R9: start modes
    setup("R9", 4, 0, 1, 0, 1, 1);    idle(50); strobe(1, 0, 0, 0); idle(3);
    strobe(0, 0, 0, 1); idle(40);
    setup("R9", 4, 0, 1, 0, 0, 1);    idle(45); strobe(1, 0, 0, 0); strobe(0, 0, 0, 1); idle(30);
    setup("R9", 4, 1, 0, 0, 0, 2);    idle(45); strobe(0, 0, 1, 0); idle(6);
    strobe(0, 0, 1, 0); idle(40); strobe(0, 0, 1, 0); idle(30);
    setup("R9", 3, 0, 0, 0, 0, 3);    idle(60);
    done = 1;
    summary();
    $finish;
  end
endmodule